// File: doc/BRIEF.md
# Writeback Queue with Register-File Commit

This block is a short in-order queue at the tail of an execution pipeline. Completed results enter through a valid/ready input. Each result can name one general-register destination, one special-register destination, both, or neither. The entry at the head of the queue performs its register writes through two independent valid/ready write ports. In the same cycles it broadcasts the values being written on bypass outputs, so that waiting consumers can pick them up early. Only after every write the entry asked for has been accepted does the queue present the entry's completion record on a valid/ready output and release it.

Back-pressure works the same way on every stream. A transfer happens on a rising clock edge where both valid and ready are high. Once a valid is raised, it and its payload stay unchanged until that transfer happens. `in_ready` depends only on occupancy: it is low exactly when all `DEPTH` entries are in use. An accept and a release in the same cycle are both performed. The operation type is consumed before this stage and does not appear at this block. On the output, the special-destination data is renamed as a flags field and the general-destination data becomes the data field.

Top module: `wbq_commit`

## Requirements
- R1: After a synchronous active-low reset the queue is empty: `out_valid`, `gw_valid`, `sw_valid`, `byp_g_valid` and `byp_s_valid` are 0 and `in_ready` is 1.
- R2: Entries leave in arrival order. On the output, `out_flags` equals the entry's special data and `out_data` equals its general data. The context, front-end, engine and packet ids, the exception code, the no-sequence flag and the address are passed through unchanged.
- R3: For a head entry with `in_gwr`=1, `gw_valid` is high with the entry's engine id, register number and data, and it holds them stable until `gw_ready` is sampled high.
- R4: For a head entry with `in_swr`=1, the special write port behaves the same way, with its own `sw_ready` and independent of the general port.
- R5: Each requested write is accepted exactly once per entry. The write valid is low in the cycle after its handshake.
- R6: `out_valid` is never high while the head entry still has a write pending. It rises in the cycle after the last pending write is accepted.
- R7: `byp_g_valid`/`byp_s_valid` are high exactly when `gw_valid`/`sw_valid` are. The bypass register number, data and `byp_eng` then equal the values on the write port.
- R8: An entry with both write flags 0 never raises `gw_valid` or `sw_valid`. It raises `out_valid` in the cycle after it is accepted, provided it is at the head.
- R9: With `DEPTH` entries held, `in_ready` is 0 and input presented on `in_valid` is not stored.
- R10: An accept and a release in the same cycle are both performed, and the occupancy is unchanged.
- R11: While `out_ready` is 0, `out_valid` and the output record stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Result offered |
| in_ready | output | 1 | Queue can take a result |
| in_ctx | input | CTX_W | Context id |
| in_fe | input | FE_W | Front-end id |
| in_eng | input | ENG_W | Engine id |
| in_pkt | input | PKT_W | Packet id |
| in_gwr | input | 1 | General destination requested |
| in_greg | input | GREG_W | General register number |
| in_gdata | input | GDATA_W | General result data |
| in_swr | input | 1 | Special destination requested |
| in_sreg | input | SREG_W | Special register number |
| in_sdata | input | SDATA_W | Special result data |
| in_exc | input | EXC_W | Exception code |
| in_noseq | input | 1 | No-sequence flag |
| in_addr | input | ADDR_W | Address |
| gw_valid | output | 1 | General write request |
| gw_ready | input | 1 | General write accepted |
| gw_eng | output | ENG_W | Engine id of general write |
| gw_reg | output | GREG_W | General register number |
| gw_data | output | GDATA_W | General write data |
| sw_valid | output | 1 | Special write request |
| sw_ready | input | 1 | Special write accepted |
| sw_eng | output | ENG_W | Engine id of special write |
| sw_reg | output | SREG_W | Special register number |
| sw_data | output | SDATA_W | Special write data |
| byp_eng | output | ENG_W | Engine id of broadcast |
| byp_g_valid | output | 1 | General broadcast valid |
| byp_g_reg | output | GREG_W | General broadcast register |
| byp_g_data | output | GDATA_W | General broadcast data |
| byp_s_valid | output | 1 | Special broadcast valid |
| byp_s_reg | output | SREG_W | Special broadcast register |
| byp_s_data | output | SDATA_W | Special broadcast data |
| out_valid | output | 1 | Completion record offered |
| out_ready | input | 1 | Downstream takes record |
| out_ctx | output | CTX_W | Context id |
| out_fe | output | FE_W | Front-end id |
| out_eng | output | ENG_W | Engine id |
| out_pkt | output | PKT_W | Packet id |
| out_flags | output | SDATA_W | Special data as flags |
| out_data | output | GDATA_W | General data |
| out_exc | output | EXC_W | Exception code |
| out_noseq | output | 1 | No-sequence flag |
| out_addr | output | ADDR_W | Address |

## Verification
Suppose a per-entry write-done bit is not cleared on release. Then the next entry with the same destination kind skips its register write, and the write count at the port comes up one short as soon as that entry reaches the head. A done bit that never sets does the opposite: the write valid stays high after its handshake, which shows a duplicate write one cycle later, and the release never arrives. A pointer or occupancy fault shows up as reordered packet ids on the output or as a wrong `in_ready` when the queue is full. Both appear within `DEPTH` releases.

// File: rtl/wbq_pkg.sv
package wbq_pkg;
  // Width of an index into a store of d slots (at least one bit).
  function automatic int unsigned idx_width(input int unsigned d);
    return (d > 1) ? $clog2(d) : 1;
  endfunction
  // Width of a counter that can hold 0..d.
  function automatic int unsigned cnt_width(input int unsigned d);
    return $clog2(d + 1);
  endfunction
endpackage

// File: rtl/wbq_fifo.sv
module wbq_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wdata,
  output logic             full,
  output logic             empty,
  output logic [WIDTH-1:0] rdata
);
  localparam int unsigned PTR_W = wbq_pkg::idx_width(DEPTH);
  localparam int unsigned CNT_W = wbq_pkg::cnt_width(DEPTH);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] slot [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign rdata = slot[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) slot[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/wbq_commit_ctl.sv
module wbq_commit_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic head_valid,
  input  logic head_gwr,
  input  logic head_swr,
  input  logic gw_ready,
  input  logic sw_ready,
  input  logic release_now,
  output logic gw_valid,
  output logic sw_valid,
  output logic release_ok
);
  logic g_done, s_done;

  assign gw_valid   = head_valid & head_gwr & ~g_done;
  assign sw_valid   = head_valid & head_swr & ~s_done;
  assign release_ok = head_valid & (~head_gwr | g_done) & (~head_swr | s_done);

  always_ff @(posedge clk) begin
    if (!rst_n || release_now) begin
      g_done <= 1'b0;
      s_done <= 1'b0;
    end else begin
      if (gw_valid && gw_ready) g_done <= 1'b1;
      if (sw_valid && sw_ready) s_done <= 1'b1;
    end
  end
endmodule

// File: rtl/wbq_commit.sv
module wbq_commit #(
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned CTX_W   = 2,
  parameter int unsigned FE_W    = 2,
  parameter int unsigned ENG_W   = 2,
  parameter int unsigned PKT_W   = 4,
  parameter int unsigned GREG_W  = 5,
  parameter int unsigned GDATA_W = 32,
  parameter int unsigned SREG_W  = 3,
  parameter int unsigned SDATA_W = 8,
  parameter int unsigned EXC_W   = 4,
  parameter int unsigned ADDR_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [CTX_W-1:0]   in_ctx,
  input  logic [FE_W-1:0]    in_fe,
  input  logic [ENG_W-1:0]   in_eng,
  input  logic [PKT_W-1:0]   in_pkt,
  input  logic               in_gwr,
  input  logic [GREG_W-1:0]  in_greg,
  input  logic [GDATA_W-1:0] in_gdata,
  input  logic               in_swr,
  input  logic [SREG_W-1:0]  in_sreg,
  input  logic [SDATA_W-1:0] in_sdata,
  input  logic [EXC_W-1:0]   in_exc,
  input  logic               in_noseq,
  input  logic [ADDR_W-1:0]  in_addr,
  output logic               gw_valid,
  input  logic               gw_ready,
  output logic [ENG_W-1:0]   gw_eng,
  output logic [GREG_W-1:0]  gw_reg,
  output logic [GDATA_W-1:0] gw_data,
  output logic               sw_valid,
  input  logic               sw_ready,
  output logic [ENG_W-1:0]   sw_eng,
  output logic [SREG_W-1:0]  sw_reg,
  output logic [SDATA_W-1:0] sw_data,
  output logic [ENG_W-1:0]   byp_eng,
  output logic               byp_g_valid,
  output logic [GREG_W-1:0]  byp_g_reg,
  output logic [GDATA_W-1:0] byp_g_data,
  output logic               byp_s_valid,
  output logic [SREG_W-1:0]  byp_s_reg,
  output logic [SDATA_W-1:0] byp_s_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [CTX_W-1:0]   out_ctx,
  output logic [FE_W-1:0]    out_fe,
  output logic [ENG_W-1:0]   out_eng,
  output logic [PKT_W-1:0]   out_pkt,
  output logic [SDATA_W-1:0] out_flags,
  output logic [GDATA_W-1:0] out_data,
  output logic [EXC_W-1:0]   out_exc,
  output logic               out_noseq,
  output logic [ADDR_W-1:0]  out_addr
);
  localparam int unsigned ENT_W = CTX_W + FE_W + ENG_W + PKT_W + 1 + GREG_W + GDATA_W
                                + 1 + SREG_W + SDATA_W + EXC_W + 1 + ADDR_W;

  logic             push, pop, full, empty;
  logic [ENT_W-1:0] wr_ent, hd_ent;
  logic             release_ok;

  // Head entry fields
  logic [CTX_W-1:0]   h_ctx;
  logic [FE_W-1:0]    h_fe;
  logic [ENG_W-1:0]   h_eng;
  logic [PKT_W-1:0]   h_pkt;
  logic               h_gwr, h_swr, h_noseq;
  logic [GREG_W-1:0]  h_greg;
  logic [GDATA_W-1:0] h_gdata;
  logic [SREG_W-1:0]  h_sreg;
  logic [SDATA_W-1:0] h_sdata;
  logic [EXC_W-1:0]   h_exc;
  logic [ADDR_W-1:0]  h_addr;

  assign wr_ent = {in_ctx, in_fe, in_eng, in_pkt, in_gwr, in_greg, in_gdata,
                   in_swr, in_sreg, in_sdata, in_exc, in_noseq, in_addr};
  assign {h_ctx, h_fe, h_eng, h_pkt, h_gwr, h_greg, h_gdata,
          h_swr, h_sreg, h_sdata, h_exc, h_noseq, h_addr} = hd_ent;

  assign in_ready = ~full;
  assign push     = in_valid & ~full;
  assign out_valid = release_ok;
  assign pop      = release_ok & out_ready;

  wbq_fifo #(.WIDTH(ENT_W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .pop   (pop),
    .wdata (wr_ent),
    .full  (full),
    .empty (empty),
    .rdata (hd_ent)
  );

  wbq_commit_ctl u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .head_valid  (~empty),
    .head_gwr    (h_gwr),
    .head_swr    (h_swr),
    .gw_ready    (gw_ready),
    .sw_ready    (sw_ready),
    .release_now (pop),
    .gw_valid    (gw_valid),
    .sw_valid    (sw_valid),
    .release_ok  (release_ok)
  );

  // Register-file write ports
  assign gw_eng  = h_eng;
  assign gw_reg  = h_greg;
  assign gw_data = h_gdata;
  assign sw_eng  = h_eng;
  assign sw_reg  = h_sreg;
  assign sw_data = h_sdata;

  // Bypass broadcast follows the write ports cycle for cycle
  assign byp_eng     = h_eng;
  assign byp_g_valid = gw_valid;
  assign byp_g_reg   = h_greg;
  assign byp_g_data  = h_gdata;
  assign byp_s_valid = sw_valid;
  assign byp_s_reg   = h_sreg;
  assign byp_s_data  = h_sdata;

  // Completion record
  assign out_ctx   = h_ctx;
  assign out_fe    = h_fe;
  assign out_eng   = h_eng;
  assign out_pkt   = h_pkt;
  assign out_flags = h_sdata;
  assign out_data  = h_gdata;
  assign out_exc   = h_exc;
  assign out_noseq = h_noseq;
  assign out_addr  = h_addr;
endmodule

// File: rtl/wbq_commit_chk.sv
module wbq_commit_chk #(
  parameter int unsigned ENG_W   = 2,
  parameter int unsigned PKT_W   = 4,
  parameter int unsigned GREG_W  = 5,
  parameter int unsigned GDATA_W = 32,
  parameter int unsigned SREG_W  = 3,
  parameter int unsigned SDATA_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_ready,
  input logic               gw_valid,
  input logic               gw_ready,
  input logic [ENG_W-1:0]   gw_eng,
  input logic [GREG_W-1:0]  gw_reg,
  input logic [GDATA_W-1:0] gw_data,
  input logic               sw_valid,
  input logic               sw_ready,
  input logic [ENG_W-1:0]   sw_eng,
  input logic [SREG_W-1:0]  sw_reg,
  input logic [SDATA_W-1:0] sw_data,
  input logic [ENG_W-1:0]   byp_eng,
  input logic               byp_g_valid,
  input logic [GREG_W-1:0]  byp_g_reg,
  input logic [GDATA_W-1:0] byp_g_data,
  input logic               byp_s_valid,
  input logic [SREG_W-1:0]  byp_s_reg,
  input logic [SDATA_W-1:0] byp_s_data,
  input logic               out_valid,
  input logic               out_ready,
  input logic [PKT_W-1:0]   out_pkt
);
  p_reset_empty_r1: assert property (@(posedge clk)
    !rst_n |=> !out_valid && !gw_valid && !sw_valid && in_ready);

  p_gw_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gw_valid && !gw_ready |=> gw_valid && $stable(gw_reg) && $stable(gw_data) && $stable(gw_eng));

  p_sw_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sw_valid && !sw_ready |=> sw_valid && $stable(sw_reg) && $stable(sw_data) && $stable(sw_eng));

  p_gw_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gw_valid && gw_ready |=> !gw_valid);

  p_sw_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sw_valid && sw_ready |=> !sw_valid);

  p_writes_before_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !gw_valid && !sw_valid);

  p_byp_gen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gw_valid |-> byp_g_valid && byp_g_reg == gw_reg && byp_g_data == gw_data && byp_eng == gw_eng);

  p_byp_spec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sw_valid |-> byp_s_valid && byp_s_reg == sw_reg && byp_s_data == sw_data && byp_eng == sw_eng);

  p_out_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pkt));
endmodule

bind wbq_commit wbq_commit_chk #(
  .ENG_W(ENG_W), .PKT_W(PKT_W), .GREG_W(GREG_W), .GDATA_W(GDATA_W),
  .SREG_W(SREG_W), .SDATA_W(SDATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
  .gw_valid(gw_valid), .gw_ready(gw_ready), .gw_eng(gw_eng), .gw_reg(gw_reg), .gw_data(gw_data),
  .sw_valid(sw_valid), .sw_ready(sw_ready), .sw_eng(sw_eng), .sw_reg(sw_reg), .sw_data(sw_data),
  .byp_eng(byp_eng), .byp_g_valid(byp_g_valid), .byp_g_reg(byp_g_reg), .byp_g_data(byp_g_data),
  .byp_s_valid(byp_s_valid), .byp_s_reg(byp_s_reg), .byp_s_data(byp_s_data),
  .out_valid(out_valid), .out_ready(out_ready), .out_pkt(out_pkt)
);

// File: tb/tb_wbq_commit.sv
`timescale 1ns/1ps
module tb_wbq_commit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        in_valid = 0, in_ready;
  logic [1:0]  in_ctx = 0, in_fe = 0, in_eng = 0;
  logic [3:0]  in_pkt = 0;
  logic        in_gwr = 0, in_swr = 0, in_noseq = 0;
  logic [4:0]  in_greg = 0;
  logic [31:0] in_gdata = 0, in_addr = 0;
  logic [2:0]  in_sreg = 0;
  logic [7:0]  in_sdata = 0;
  logic [3:0]  in_exc = 0;
  logic        gw_valid, gw_ready = 0, sw_valid, sw_ready = 0;
  logic [1:0]  gw_eng, sw_eng, byp_eng;
  logic [4:0]  gw_reg, byp_g_reg;
  logic [31:0] gw_data, byp_g_data;
  logic [2:0]  sw_reg, byp_s_reg;
  logic [7:0]  sw_data, byp_s_data;
  logic        byp_g_valid, byp_s_valid;
  logic        out_valid, out_ready = 0, out_noseq;
  logic [1:0]  out_ctx, out_fe, out_eng;
  logic [3:0]  out_pkt, out_exc;
  logic [7:0]  out_flags;
  logic [31:0] out_data, out_addr;

  wbq_commit dut (.*);

  typedef struct packed {
    logic [1:0] ctx; logic [1:0] fe; logic [1:0] eng; logic [3:0] pkt;
    logic gwr; logic [4:0] greg; logic [31:0] gdata;
    logic swr; logic [2:0] sreg; logic [7:0] sdata;
    logic [3:0] exc; logic noseq; logic [31:0] addr;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 2'd2, 2'd3, 4'd0, 1'b1, 5'd7,  32'hDEAD_0001, 1'b0, 3'd0, 8'h11, 4'd0, 1'b0, 32'h0000_1000},
    '{2'd2, 2'd0, 2'd1, 4'd1, 1'b0, 5'd0,  32'h1234_5678, 1'b1, 3'd5, 8'hA5, 4'd3, 1'b1, 32'h0000_2004},
    '{2'd3, 2'd1, 2'd2, 4'd2, 1'b1, 5'd31, 32'hFFFF_FFFF, 1'b1, 3'd7, 8'hFF, 4'd15,1'b0, 32'hFFFF_FFFC},
    '{2'd0, 2'd3, 2'd0, 4'd3, 1'b0, 5'd1,  32'h0BAD_F00D, 1'b0, 3'd2, 8'h3C, 4'd9, 1'b1, 32'h8000_0000},
    '{2'd1, 2'd1, 2'd1, 4'd4, 1'b1, 5'd0,  32'h0000_0000, 1'b1, 3'd0, 8'h00, 4'd1, 1'b0, 32'h0000_0010},
    '{2'd2, 2'd2, 2'd2, 4'd5, 1'b1, 5'd16, 32'hCAFE_BABE, 1'b0, 3'd3, 8'h5A, 4'd2, 1'b1, 32'h1234_0000},
    '{2'd3, 2'd3, 2'd3, 4'd6, 1'b0, 5'd9,  32'h0F0F_0F0F, 1'b1, 3'd1, 8'h81, 4'd7, 1'b0, 32'h0000_0FF8},
    '{2'd0, 2'd0, 2'd0, 4'd7, 1'b0, 5'd2,  32'h5555_AAAA, 1'b0, 3'd4, 8'h7E, 4'd0, 1'b0, 32'h0000_0000}
  };

  int errors = 0, checks = 0;
  int gcnt = 0, scnt = 0, byp_bad = 0, byp_seen = 0;
  logic [4:0]  last_greg;  logic [31:0] last_gdata; logic [1:0] last_geng;
  logic [2:0]  last_sreg;  logic [7:0]  last_sdata; logic [1:0] last_seng;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Write handshake monitor (values before the edge)
  always @(posedge clk) if (rst_n) begin
    if (gw_valid && gw_ready) begin gcnt++; last_greg = gw_reg; last_gdata = gw_data; last_geng = gw_eng; end
    if (sw_valid && sw_ready) begin scnt++; last_sreg = sw_reg; last_sdata = sw_data; last_seng = sw_eng; end
  end

  // Bypass monitor, R7
  always @(negedge clk) if (rst_n) begin
    if (byp_g_valid != gw_valid || byp_s_valid != sw_valid) byp_bad++;
    if (gw_valid) begin byp_seen++; if (byp_g_reg != gw_reg || byp_g_data != gw_data || byp_eng != gw_eng) byp_bad++; end
    if (sw_valid) begin byp_seen++; if (byp_s_reg != sw_reg || byp_s_data != sw_data || byp_eng != sw_eng) byp_bad++; end
  end

  task automatic drive(input vec_t v);
    in_ctx = v.ctx; in_fe = v.fe; in_eng = v.eng; in_pkt = v.pkt;
    in_gwr = v.gwr; in_greg = v.greg; in_gdata = v.gdata;
    in_swr = v.swr; in_sreg = v.sreg; in_sdata = v.sdata;
    in_exc = v.exc; in_noseq = v.noseq; in_addr = v.addr;
  endtask

  task automatic push(input vec_t v);
    @(negedge clk);
    drive(v);
    in_valid = 1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 0;
  endtask

  task automatic pop_one();
    @(negedge clk);
    out_ready = 1;
    @(posedge clk);
    #1 out_ready = 0;
  endtask

  function automatic vec_t plain(input logic [3:0] pkt);
    vec_t v = '0;
    v.pkt = pkt; v.gdata = {28'h0, pkt}; v.addr = {pkt, 28'h0};
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired R1 actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int g0, s0;
    vec_t v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(!out_valid && !gw_valid && !sw_valid, "R1 valids low after reset", {out_valid, gw_valid, sw_valid}, 0);
    chk(!byp_g_valid && !byp_s_valid, "R1 bypass valids low", {byp_g_valid, byp_s_valid}, 0);
    chk(in_ready, "R1 in_ready high when empty", in_ready, 1);

    // Table walk: one entry at a time, write ports always ready
    gw_ready = 1; sw_ready = 1;
    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      g0 = gcnt; s0 = scnt;
      push(v);
      @(negedge clk);
      for (int k = 0; k < 20 && !out_valid; k++) @(negedge clk);
      chk(gcnt - g0 == int'(v.gwr), v.gwr ? "R5 one general write" : "R8 no general write", gcnt - g0, v.gwr);
      chk(scnt - s0 == int'(v.swr), v.swr ? "R5 one special write" : "R8 no special write", scnt - s0, v.swr);
      if (v.gwr) chk(last_greg == v.greg && last_gdata == v.gdata && last_geng == v.eng,
                     "R3 general write payload", last_gdata, v.gdata);
      if (v.swr) chk(last_sreg == v.sreg && last_sdata == v.sdata && last_seng == v.eng,
                     "R4 special write payload", last_sdata, v.sdata);
      chk(out_valid, "R6 release after writes", out_valid, 1);
      chk(out_flags == v.sdata && out_data == v.gdata, "R2 flags/data repack",
          {out_flags, out_data}, {v.sdata, v.gdata});
      chk(out_ctx == v.ctx && out_fe == v.fe && out_eng == v.eng && out_pkt == v.pkt &&
          out_exc == v.exc && out_noseq == v.noseq && out_addr == v.addr, "R2 pass-through fields",
          {out_pkt, out_addr}, {v.pkt, v.addr});
      pop_one();
      @(negedge clk);
      chk(!out_valid, "R10 queue empty after release", out_valid, 0);
    end

    // R3/R6/R5: general write held under back-pressure, release one cycle after ack
    gw_ready = 0; sw_ready = 0;
    v = plain(4'd9); v.gwr = 1; v.greg = 5'd12; v.gdata = 32'h600D_0012; v.swr = 1; v.sreg = 3'd6; v.sdata = 8'h66;
    push(v);
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      chk(gw_valid && gw_reg == 5'd12 && gw_data == 32'h600D_0012, "R3 general write held", gw_data, 32'h600D_0012);
      chk(!out_valid, "R6 no release with writes pending", out_valid, 0);
      @(negedge clk);
    end
    sw_ready = 1;
    @(negedge clk);
    chk(!sw_valid && gw_valid, "R4 special port independent of general", {sw_valid, gw_valid}, 2'b01);
    chk(!out_valid, "R6 no release while general pending", out_valid, 0);
    gw_ready = 1;
    @(negedge clk);
    chk(!gw_valid, "R5 general write valid drops after ack", gw_valid, 0);
    chk(out_valid && out_pkt == 4'd9, "R6 release one cycle after last ack", out_pkt, 9);
    pop_one();

    // R9/R11: fill with plain entries, downstream stalled
    for (int i = 0; i < 4; i++) push(plain(4'(i)));
    @(negedge clk);
    chk(!in_ready, "R9 in_ready low when full", in_ready, 0);
    drive(plain(4'd15)); in_valid = 1;
    repeat (3) @(negedge clk);
    chk(out_valid && out_pkt == 4'd0, "R11 output stable under stall", out_pkt, 0);
    in_valid = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(out_valid && out_pkt == 4'(i), "R2 arrival order", out_pkt, i);
      pop_one();
    end
    @(negedge clk);
    chk(!out_valid, "R9 extra input not stored", out_valid, 0);

    // R10 and R8: simultaneous accept and release
    push(plain(4'd10));
    @(negedge clk);
    chk(out_valid && out_pkt == 4'd10, "R8 plain entry released next cycle", out_pkt, 10);
    drive(plain(4'd11)); in_valid = 1; out_ready = 1;
    @(posedge clk);
    #1 in_valid = 0; out_ready = 0;
    @(negedge clk);
    chk(out_valid && out_pkt == 4'd11, "R10 new entry at head", out_pkt, 11);
    pop_one();
    @(negedge clk);
    chk(!out_valid && in_ready, "R10 occupancy unchanged then empty", out_valid, 0);

    chk(byp_bad == 0 && byp_seen > 0, "R7 bypass mirrors write ports", byp_bad, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule